// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block makes the bit clock for one serial channel from a fast reference clock. A prescaler first slows the reference by 1 or by 4. An 11-bit down-counter then divides the prescaled clock by any whole number from 1 to 2048. The output keeps an exact 50% duty cycle for every ratio, including the odd ones.

Everything runs on the single reference clock `clk`. The prescaled clock is defined as one period of two prescaler ticks, so the counter works in half periods. A ratio of N gives exactly N half periods high and N half periods low. With the prescaler at 1 the output period is 2·N reference cycles. With the prescaler at 4 it is 8·N reference cycles.

Two independent selectors send either the generated clock or an external pin clock to the receive and transmit sides. A channel that runs from the generated clock needs a ratio of at least 3. In UART use the clock runs at 16 times the baud rate.

Top module: `baud_clk_gen`

## Requirements
- R1: While `rst` is high, `baud_clk` is low and the counter is cleared. The first prescaler tick after reset therefore drives `baud_clk` high, and it stays high for a full phase.
- R2: With `pre_div4` = 0 and divider field F, `baud_clk` has a period of 2·(F+1) reference cycles. The divide ratio is F+1: a field of 0x000 divides by 1 and 0x7FF divides by 2048.
- R3: For every ratio, odd ones included, the high time of `baud_clk` equals its low time. Each phase is F+1 half periods of the prescaled clock.
- R4: With `pre_div4` = 1, the prescaler issues one tick every 4 reference cycles. The high time and the low time are then each 4·(F+1) reference cycles.
- R5: With F = 0, `baud_clk` is the prescaled clock itself. Its high and low times are each 1 reference cycle with `pre_div4` = 0, and 4 cycles with `pre_div4` = 1.
- R6: A new divider field is loaded only when the counter reloads. The phase in progress completes with the old ratio, and the following phases use the new one.
- R7: `rx_clk` follows `ext_rx_clk` when `rx_src_ext` = 1 and follows `baud_clk` when it is 0, whatever `tx_src_ext` is set to.
- R8: `tx_clk` follows `ext_tx_clk` when `tx_src_ext` = 1 and follows `baud_clk` when it is 0, whatever `rx_src_ext` is set to.
- R9: On each prescaler tick the counter decrements by one. When a tick finds the counter at zero, the counter reloads from the divider field and `baud_clk` toggles.
- R10: `baud_clk` changes only on a tick that finds the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, at twice the undivided prescaled rate |
| rst | input | 1 | Synchronous reset, active high |
| div_field | input | 11 | Divider field F; the ratio is F+1 |
| pre_div4 | input | 1 | Prescaler select: 0 divides by 1, 1 divides by 4 |
| rx_src_ext | input | 1 | Receive clock source: 1 selects the external pin, 0 the generated clock |
| tx_src_ext | input | 1 | Transmit clock source: 1 selects the external pin, 0 the generated clock |
| ext_rx_clk | input | 1 | External receive clock from the pin |
| ext_tx_clk | input | 1 | External transmit clock from the pin |
| baud_clk | output | 1 | Generated 50%-duty baud clock |
| rx_clk | output | 1 | Clock selected for the receive side |
| tx_clk | output | 1 | Clock selected for the transmit side |

## Verification
On every cycle, the assertions check the internal sequencing. They confirm that the counter decrements once per tick and reloads from the field at zero. They confirm that the output toggles exactly at a terminal count and holds steady otherwise, that divide-by-4 ticks never fall on consecutive cycles, and that reset leaves the output low.

Some behaviour shows only over whole periods, so only the bench scenarios can show it. These scenarios measure high and low times for ratios 1, 2, 3, 5 and 2048 under both prescaler settings. They also check that a divider change mid-phase does not cut the running phase short, and that each source selector steers its own output.

// File: rtl/baud_clk_gen.sv
module baud_clk_gen #(
  parameter int DIV_W = 11,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_field,
  input  logic             pre_div4,
  input  logic             rx_src_ext,
  input  logic             tx_src_ext,
  input  logic             ext_rx_clk,
  input  logic             ext_tx_clk,
  output logic             baud_clk,
  output logic             rx_clk,
  output logic             tx_clk
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] cnt;
  logic             tick;
  logic             term;
  logic             clk_q;

  // one tick per half period of the prescaled clock
  assign tick = !pre_div4 || (pre_cnt == PRE_LAST);
  assign term = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (term) cnt <= div_field;
    else if (tick) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       clk_q <= 1'b0;
    else if (term) clk_q <= ~clk_q;
  end

  assign baud_clk = clk_q;
  assign rx_clk   = rx_src_ext ? ext_rx_clk : clk_q;
  assign tx_clk   = tx_src_ext ? ext_tx_clk : clk_q;
endmodule

module baud_clk_gen_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             pre_div4,
  input logic [DIV_W-1:0] div_field,
  input logic             tick,
  input logic [DIV_W-1:0] cnt,
  input logic             baud_clk
);
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !baud_clk)
    else $error("baud_clk not low after reset");

  p_count_down_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != '0) |=> cnt == $past(cnt) - 1'b1)
    else $error("counter did not decrement on tick");

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0) |=> cnt == $past(div_field))
    else $error("counter did not reload from field");

  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0) |=> baud_clk != $past(baud_clk))
    else $error("output missed a toggle at terminal count");

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(tick && cnt == '0) |=> $stable(baud_clk))
    else $error("output moved away from terminal count");

  p_pre_space_r4: assert property (@(posedge clk) disable iff (rst)
    (pre_div4 && tick) |=> (!pre_div4 || !tick))
    else $error("divide-by-4 ticks too close together");
endmodule

bind baud_clk_gen baud_clk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .pre_div4(pre_div4), .div_field(div_field),
  .tick(tick), .cnt(cnt), .baud_clk(baud_clk)
);

// File: tb/tb_baud_clk_gen.sv
module tb_baud_clk_gen;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] div_field = '0;
  logic        pre_div4 = 1'b0;
  logic        rx_src_ext = 1'b0;
  logic        tx_src_ext = 1'b0;
  logic        ext_rx_clk = 1'b0;
  logic        ext_tx_clk = 1'b0;
  logic        baud_clk, rx_clk, tx_clk;

  int checks = 0;
  int failures = 0;

  baud_clk_gen dut (
    .clk(clk), .rst(rst), .div_field(div_field), .pre_div4(pre_div4),
    .rx_src_ext(rx_src_ext), .tx_src_ext(tx_src_ext),
    .ext_rx_clk(ext_rx_clk), .ext_tx_clk(ext_tx_clk),
    .baud_clk(baud_clk), .rx_clk(rx_clk), .tx_clk(tx_clk)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = baud_clk;
    forever begin
      @(negedge clk);
      if (!prev && baud_clk) break;
      prev = baud_clk;
    end
  endtask

  // called right after a rising sample; counts high then low samples
  task automatic count_phases(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (baud_clk) begin hi++; @(negedge clk); end
    while (!baud_clk) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    int hi, lo;
    rst = 1'b1;
    div_field = 11'd4;
    pre_div4 = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "baud_clk during reset", baud_clk, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "baud_clk after first tick", baud_clk, 1);
    count_phases(hi, lo);
    check("R1", "first high phase F=4", hi, 5);
    check("R3", "first low phase F=4", lo, 5);
  endtask

  task automatic t_ratio(input int f, input bit p4);
    int hi, lo, unit;
    string req;
    div_field = f[10:0];
    pre_div4 = p4;
    unit = p4 ? 4 : 1;
    req = (f == 0) ? "R5" : (p4 ? "R4" : "R2");
    wait_rise();
    wait_rise();
    count_phases(hi, lo);
    check(req, $sformatf("high time F=%0d pre4=%0d", f, p4), hi, unit * (f + 1));
    check("R3", $sformatf("low time F=%0d pre4=%0d", f, p4), lo, unit * (f + 1));
  endtask

  task automatic t_change();
    int hi, lo;
    pre_div4 = 1'b0;
    div_field = 11'd9;
    wait_rise();
    wait_rise();
    div_field = 11'd2;
    count_phases(hi, lo);
    check("R6", "phase in progress keeps old ratio", hi, 10);
    check("R6", "next phase uses new ratio", lo, 3);
  endtask

  task automatic t_mux();
    div_field = 11'd3;
    pre_div4 = 1'b0;
    rx_src_ext = 1'b1;
    tx_src_ext = 1'b0;
    for (int i = 0; i < 6; i++) begin
      ext_rx_clk = i[0];
      ext_tx_clk = ~i[0];
      @(negedge clk);
      #1;
      check("R7", "rx follows external pin", rx_clk, ext_rx_clk);
      check("R8", "tx follows generated clock", tx_clk, baud_clk);
    end
    rx_src_ext = 1'b0;
    tx_src_ext = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ext_rx_clk = ~i[0];
      ext_tx_clk = i[0];
      @(negedge clk);
      #1;
      check("R7", "rx follows generated clock", rx_clk, baud_clk);
      check("R8", "tx follows external pin", tx_clk, ext_tx_clk);
    end
    tx_src_ext = 1'b0;
  endtask

  initial begin
    #(CLK_P * WATCHDOG);
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio(0, 1'b0);
    t_ratio(1, 1'b0);
    t_ratio(2, 1'b0);
    t_ratio(4, 1'b0);
    t_ratio(2047, 1'b0);
    t_ratio(0, 1'b1);
    t_ratio(1, 1'b1);
    t_ratio(2, 1'b1);
    t_ratio(4, 1'b1);
    t_ratio(2047, 1'b1);
    t_change();
    t_mux();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule